// File: doc/BRIEF.md
# I2C Register-Bank Target with Coherent Time Snapshot

This block is the serial target side of a small timekeeping peripheral. An I2C host reaches a bank of sixteen 8-bit registers through it. The block watches the SCL and SDA lines, which it samples with a faster system clock. It pulls SDA low through an output-enable to acknowledge bytes and to send data. It never drives SCL.

A write transaction has three parts. The first is the device byte for a write. The second is a word-address byte that sets an internal pointer. After that come any number of data bytes. A read uses a write of the word address, then a repeated START, then the read device byte. In both directions the pointer advances by one after every data byte, and it wraps at the top of the bank.

Seven consecutive addresses do not return stored values. They return the external time counters presented on `timeNow`. These counters are captured once, when a read device byte is acknowledged. Every byte of a multi-byte read therefore belongs to the same instant, even if the counters roll over during the transfer.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset the target does not drive SDA, all sixteen registers read 0 on `regsOut`, and the word pointer is 0.
- R2: A START (SDA falling while SCL is high) restarts device-byte reception from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the target to idle, and clocked bytes after a STOP are ignored until the next START.
- R3: The device byte is sent MSB first. The values 0xA2 (write) and 0xA3 (read) are acknowledged by pulling SDA low during the ninth clock. Any other value gets no acknowledge, and the target then leaves SDA released until the next START.
- R4: In a write, the first byte after 0xA2 loads the pointer from its low four bits; the upper four bits are ignored. Each later byte is acknowledged and stored at the pointer, and the pointer then increments.
- R5: The pointer wraps from 15 to 0 in both writes and reads.
- R6: After 0xA3, the target sends bytes MSB first, starting at the current pointer, and increments the pointer for each byte sent. Each bit is placed on SDA while SCL is low.
- R7: When the host answers a sent byte with NACK (SDA high on the ninth clock), the target stops sending and leaves SDA released until the next START.
- R8: Addresses 2 to 8 read the value of `timeNow` that was captured when 0xA3 was acknowledged. Address 2+k returns `timeNow[8k+7:8k]`. Changes of `timeNow` during the read do not affect the bytes returned.
- R9: Host writes to addresses 2 to 8 appear on `regsOut`, so the counters can be loaded from outside. A read of those addresses still returns the captured time, not the written value.
- R10: The target changes its SDA output-enable only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaOe | output | 1 | High pulls SDA low (open-drain drive) |
| timeNow | input | 56 | Live time counters, byte k mapped to address 2+k |
| regsOut | output | 128 | Register bank contents, register r at bits [8r+7:8r] |

## Verification
The bench sweeps every one of the 256 device-byte values. A matcher that ignored the read/write bit or compared too few bits would acknowledge a wrong value here. A write that runs past register 15 catches a pointer that saturates instead of wrapping, or that writes outside the bank.

A full sixteen-byte read changes `timeNow` after the first byte. A design that read the live counters, or took the snapshot late, would return the new values at addresses 2 to 8. A design that mixed up storage and snapshot would return the written bytes instead of the captured time.

Further cases cover a STOP followed by bytes with no START, a START inside a device byte, and clocks after a host NACK. In these a design that kept state or kept driving would acknowledge or pull SDA low.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_WORDADR,
    ST_WRDATA,
    ST_ACK,
    ST_TX,
    ST_HOSTACK
  } ctrlState_t;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic shiftRx;
    logic setPtr;
    logic wrReg;
    logic loadTx;
    logic shiftTx;
    logic takeSnap;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_rb_ctrl.sv
module i2c_rb_ctrl
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h51
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpStrobe_t  str,
  output logic       sdaBit,
  output logic       sdaOe
);

  localparam int CW = 4;

  logic [1:0] sclSy, sdaSy;
  logic sclS, sdaS, sclD, sdaD;
  logic startC, stopC, sclRise, sclFall;
  ctrlState_t state, afterAck;
  logic [CW-1:0] cnt;
  logic hostAcked;
  logic rxState, byteDone, addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSy <= 2'b11;
      sdaSy <= 2'b11;
      sclD  <= 1'b1;
      sdaD  <= 1'b1;
    end else begin
      sclSy <= {sclSy[0], sclIn};
      sdaSy <= {sdaSy[0], sdaIn};
      sclD  <= sclSy[1];
      sdaD  <= sdaSy[1];
    end
  end

  assign sclS    = sclSy[1];
  assign sdaS    = sdaSy[1];
  assign sdaBit  = sdaS;
  assign startC  = sclS & sclD & sdaD & ~sdaS;
  assign stopC   = sclS & sclD & ~sdaD & sdaS;
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;

  assign rxState  = (state == ST_DEVADR) || (state == ST_WORDADR) || (state == ST_WRDATA);
  assign byteDone = rxState && sclFall && (cnt == CW'(8));
  assign addrHit  = (rxByte[7:1] == DEV_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      afterAck  <= ST_IDLE;
      cnt       <= '0;
      hostAcked <= 1'b0;
    end else if (startC) begin
      state <= ST_DEVADR;
      cnt   <= '0;
    end else if (stopC) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_DEVADR, ST_WORDADR, ST_WRDATA: begin
          if (sclRise) cnt <= cnt + 1'b1;
          if (byteDone) begin
            if (state == ST_DEVADR) begin
              if (addrHit) begin
                state    <= ST_ACK;
                afterAck <= rxByte[0] ? ST_TX : ST_WORDADR;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state    <= ST_ACK;
              afterAck <= ST_WRDATA;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            state <= afterAck;
            cnt   <= '0;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (cnt == CW'(7)) state <= ST_HOSTACK;
            else cnt <= cnt + 1'b1;
          end
        end
        ST_HOSTACK: begin
          if (sclRise) hostAcked <= ~sdaS;
          if (sclFall) begin
            state <= hostAcked ? ST_TX : ST_IDLE;
            cnt   <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    str          = '0;
    str.shiftRx  = rxState && sclRise;
    str.takeSnap = byteDone && (state == ST_DEVADR) && addrHit && rxByte[0];
    str.setPtr   = byteDone && (state == ST_WORDADR);
    str.wrReg    = byteDone && (state == ST_WRDATA);
    str.loadTx   = sclFall && !startC && !stopC &&
                   (((state == ST_ACK) && (afterAck == ST_TX)) ||
                    ((state == ST_HOSTACK) && hostAcked));
    str.shiftTx  = sclFall && (state == ST_TX) && (cnt != CW'(7));
  end

  always_comb begin
    case (state)
      ST_ACK:  sdaOe = 1'b1;
      ST_TX:   sdaOe = ~txMsb;
      default: sdaOe = 1'b0;
    endcase
  end

  AST_OE_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclD) |-> $stable(sdaOe)); // R10
  AST_HOSTACK_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOSTACK) |-> !sdaOe); // R7
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(str)); // R4
  AST_RX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rxState |-> (cnt <= CW'(8))); // R3

endmodule

// File: rtl/i2c_rb_data.sv
module i2c_rb_data
  import i2c_rb_pkg::*;
#(
  parameter int AW         = 4,
  parameter int TIME_BASE  = 2,
  parameter int TIME_BYTES = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 str,
  input  logic                      sdaBit,
  input  logic [TIME_BYTES*8-1:0]   timeNow,
  output logic [7:0]                rxByte,
  output logic                      txMsb,
  output logic [(1<<AW)*8-1:0]      regsOut
);

  localparam int REGS = 1 << AW;
  localparam int SW   = (TIME_BYTES > 1) ? $clog2(TIME_BYTES) : 1;
  localparam logic [AW:0] T_LO = (AW+1)'(TIME_BASE);
  localparam logic [AW:0] T_HI = (AW+1)'(TIME_BASE + TIME_BYTES);

  logic [7:0] regs [REGS];
  logic [7:0] snap [TIME_BYTES];
  logic [AW-1:0] ptr;
  logic [7:0] rxSh, txSh, rdData;
  logic [AW:0] snapOff;
  logic inTime;

  assign snapOff = {1'b0, ptr} - T_LO;
  assign inTime  = ({1'b0, ptr} >= T_LO) && ({1'b0, ptr} < T_HI);
  assign rdData  = inTime ? snap[snapOff[SW-1:0]] : regs[ptr];
  assign rxByte  = rxSh;
  assign txMsb   = txSh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0;
      txSh <= '0;
      ptr  <= '0;
      for (int i = 0; i < REGS; i++) regs[i] <= '0;
    end else begin
      if (str.shiftRx) rxSh <= {rxSh[6:0], sdaBit};
      if (str.setPtr)  ptr  <= rxSh[AW-1:0];
      if (str.wrReg) begin
        regs[ptr] <= rxSh;
        ptr       <= ptr + 1'b1;
      end
      if (str.loadTx) begin
        txSh <= rdData;
        ptr  <= ptr + 1'b1;
      end
      if (str.shiftTx) txSh <= {txSh[6:0], 1'b0};
    end
  end

  for (genvar g = 0; g < TIME_BYTES; g++) begin : gSnap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) snap[g] <= '0;
      else if (str.takeSnap) snap[g] <= timeNow[g*8 +: 8];
    end
  end

  for (genvar r = 0; r < REGS; r++) begin : gOut
    assign regsOut[r*8 +: 8] = regs[r];
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((str.loadTx || str.wrReg) && (ptr == '1)) |=> (ptr == '0)); // R5

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h51,
  parameter int         AW         = 4,
  parameter int         TIME_BASE  = 2,
  parameter int         TIME_BYTES = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  output logic                    sdaOe,
  input  logic [TIME_BYTES*8-1:0] timeNow,
  output logic [(1<<AW)*8-1:0]    regsOut
);

  dpStrobe_t str;
  logic [7:0] rxByte;
  logic txMsb, sdaBit;

  i2c_rb_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txMsb(txMsb), .str(str), .sdaBit(sdaBit), .sdaOe(sdaOe)
  );

  i2c_rb_data #(.AW(AW), .TIME_BASE(TIME_BASE), .TIME_BYTES(TIME_BYTES)) uData (
    .clk(clk), .rstN(rstN), .str(str), .sdaBit(sdaBit), .timeNow(timeNow),
    .rxByte(rxByte), .txMsb(txMsb), .regsOut(regsOut)
  );

endmodule

// File: tb/i2c_regbank_target_test.sv
module i2c_regbank_target_test;

  localparam int Q = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic hostScl = 1'b1, hostSda = 1'b1;
  logic sdaOe, sdaLine;
  logic [55:0] timeNow;
  logic [127:0] regsOut;

  assign sdaLine = hostSda & ~sdaOe;

  i2c_regbank_target uut (
    .clk(clk), .rstN(rstN), .sclIn(hostScl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .timeNow(timeNow), .regsOut(regsOut)
  );

  int nChecks = 0, nFail = 0;
  int r10Err = 0, quietErr = 0;
  bit quiet = 1'b0;
  logic prevScl = 1'b1, prevOe = 1'b0;

  always @(negedge clk) begin
    if (hostScl && prevScl && (sdaOe !== prevOe)) r10Err++;
    if (quiet && sdaOe) quietErr++;
    prevScl = hostScl;
    prevOe  = sdaOe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n*Q) @(negedge clk);
  endtask

  task automatic startC;
    hostSda = 1'b1; waitQ; hostScl = 1'b1; waitQ; hostSda = 1'b0; waitQ; hostScl = 1'b0; waitQ;
  endtask

  task automatic stopC;
    hostSda = 1'b0; waitQ; hostScl = 1'b1; waitQ; hostSda = 1'b1; waitQ(2);
  endtask

  task automatic sendBit(input bit b);
    hostSda = b; waitQ; hostScl = 1'b1; waitQ(2); hostScl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    hostSda = 1'b1; waitQ; hostScl = 1'b1; waitQ;
    acked = ~sdaLine;
    waitQ; hostScl = 1'b0;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] v);
    hostSda = 1'b1;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      waitQ; hostScl = 1'b1; waitQ;
      v = {v[6:0], sdaLine};
      waitQ; hostScl = 1'b0;
    end
    hostSda = ~ackIt; waitQ; hostScl = 1'b1; waitQ(2); hostScl = 1'b0;
    hostSda = 1'b1;
  endtask

  function automatic logic [7:0] tA(input int k);
    return 8'(8'hC0 + k);
  endfunction
  function automatic logic [7:0] tB(input int k);
    return 8'(8'h60 + 3*k);
  endfunction

  logic [7:0] expReg [16];
  logic [55:0] patA, patB;

  initial begin
    bit ack;
    logic [7:0] b, e;
    for (int k = 0; k < 7; k++) begin
      patA[k*8 +: 8] = tA(k);
      patB[k*8 +: 8] = tB(k);
    end
    for (int r = 0; r < 16; r++) expReg[r] = '0;
    rstN = 1'b0;
    timeNow = patA;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitQ;

    // R1 reset state
    chk(sdaOe == 1'b0, "R1 sdaOe after reset", int'(sdaOe), 0);
    for (int r = 0; r < 16; r++)
      chk(regsOut[r*8 +: 8] == 8'h00, "R1 register after reset", int'(regsOut[r*8 +: 8]), 0);

    // R4/R5 write with wrap, word byte 0xFE -> pointer 14
    startC;
    sendByte(8'hA2, ack); chk(ack, "R3 write device byte acked", int'(ack), 1);
    sendByte(8'hFE, ack); chk(ack, "R4 word address acked", int'(ack), 1);
    for (int k = 0; k < 18; k++) begin
      logic [7:0] v;
      v = 8'((k*29 + 3) & 255);
      sendByte(v, ack);
      chk(ack, "R4 data byte acked", int'(ack), 1);
      expReg[(14 + k) % 16] = v;
    end
    stopC;
    for (int r = 0; r < 16; r++)
      chk(regsOut[r*8 +: 8] == expReg[r], (r >= 14) ? "R5 wrapped write" : "R4 stored write",
          int'(regsOut[r*8 +: 8]), int'(expReg[r]));
    // R9 written time address visible on regsOut
    chk(regsOut[3*8 +: 8] == expReg[3], "R9 time address write on regsOut",
        int'(regsOut[3*8 +: 8]), int'(expReg[3]));

    // R3 sweep of every device byte
    for (int a = 0; a < 256; a++) begin
      if (a == 8'hA2 || a == 8'hA3) continue;
      startC;
      sendByte(8'(a), ack);
      chk(!ack, "R3 mismatched device byte not acked", int'(ack), 0);
      stopC;
    end

    // R3 after mismatch the target stays off the bus
    startC;
    quiet = 1'b1;
    sendByte(8'h50, ack);
    sendByte(8'hA2, ack);
    quiet = 1'b0;
    chk(quietErr == 0, "R3 no drive after mismatch", quietErr, 0);
    stopC;

    // R6/R8 full read from 0, time changes after first byte
    timeNow = patA;
    startC;
    sendByte(8'hA2, ack);
    sendByte(8'h00, ack);
    startC;
    sendByte(8'hA3, ack); chk(ack, "R3 read device byte acked", int'(ack), 1);
    for (int i = 0; i < 16; i++) begin
      recvByte(i != 15, b);
      if (i == 0) timeNow = patB;
      if (i >= 2 && i <= 8) begin
        e = tA(i - 2);
        chk(b == e, "R8 snapshot byte", int'(b), int'(e));
      end else begin
        e = expReg[i];
        chk(b == e, "R6 register byte", int'(b), int'(e));
      end
    end
    // R7 after NACK the target releases SDA
    quiet = 1'b1;
    recvByte(1'b0, b);
    quiet = 1'b0;
    chk(quietErr == 0, "R7 no drive after host NACK", quietErr, 0);
    chk(b == 8'hFF, "R7 bus idle after NACK", int'(b), 255);
    stopC;

    // R5/R8 read continues at wrapped pointer with a new snapshot
    startC;
    sendByte(8'hA3, ack); chk(ack, "R3 second read acked", int'(ack), 1);
    recvByte(1'b1, b); chk(b == expReg[0], "R5 read after wrap", int'(b), int'(expReg[0]));
    recvByte(1'b1, b); chk(b == expReg[1], "R6 sequential read", int'(b), int'(expReg[1]));
    recvByte(1'b0, b); chk(b == tB(0), "R8 fresh snapshot", int'(b), int'(tB(0)));
    stopC;

    // R2 bytes after STOP are ignored
    startC;
    sendByte(8'hA2, ack);
    sendByte(8'h05, ack);
    stopC;
    sendByte(8'hA2, ack);
    chk(!ack, "R2 ignored after STOP", int'(ack), 0);
    startC;
    sendByte(8'hA2, ack);
    sendByte(8'h05, ack);
    sendByte(8'h5A, ack);
    stopC;
    chk(regsOut[5*8 +: 8] == 8'h5A, "R4 write after new START", int'(regsOut[5*8 +: 8]), 8'h5A);

    // R2 START in the middle of a device byte
    startC;
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    startC;
    sendByte(8'hA2, ack); chk(ack, "R2 restart mid byte acked", int'(ack), 1);
    sendByte(8'h0A, ack);
    sendByte(8'hC3, ack);
    stopC;
    chk(regsOut[10*8 +: 8] == 8'hC3, "R2 write after mid-byte START",
        int'(regsOut[10*8 +: 8]), 8'hC3);

    // R10 SDA drive changes only while SCL low
    chk(r10Err == 0, "R10 drive change with SCL high", r10Err, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule